// File: doc/BRIEF.md
# T1 Receive Frame Timing Generator

This block turns the 1.544 MHz receive bit clock and an alignment pulse from an upstream framer into the timing strobes that downstream logic needs. The framer raises `frame_align` while the framing bit of multiframe frame 1 is on `rx_data`. From then on, a bit counter steps through the 193 bit positions of each frame and a frame counter steps through the multiframe. Position 0 is the framing bit. Positions 1 to 192 carry 24 channels of 8 bits each.

Three kinds of output come from these counters. A channel strobe marks the last bit of every channel. A sync pulse marks either every frame or only the start of each multiframe. In frame mode it can be stretched to two bits on signaling frames. A link clock and data pair picks out the overhead framing bits that belong to the selected framing mode and presents each one a bit time before the next frame starts.

All outputs are registered. During a clock cycle, each output describes the bit that is on `rx_data` in that cycle, which is the bit sampled at the closing edge of the cycle.

Top module: `t1_rx_timing`

## Requirements
- R1: While `rst` is high, all four outputs are low, and they stay low in the first cycle after `rst` falls.
- R2: When `frame_align` is high, the current bit becomes position 0 of frame 1. This holds wherever the counters were before, including in the middle of a frame. Later bits count 1, 2, … up to 192 and then wrap to 0.
- R3: `chan_clk` is high exactly at positions 8, 16, …, 192 (24 times per frame) and low at every other position.
- R4: With `sync_sel`=0 and `sync_wide`=0, `sync_pulse` is high only at position 0 of every frame.
- R5: With `sync_sel`=0 and `sync_wide`=1, `sync_pulse` is also high at position 1 of signaling frames. Signaling frames are frames 6 and 12 in D4 and frames 6, 12, 18 and 24 in the other modes. Every other frame keeps a one-bit pulse.
- R6: With `sync_sel`=1, `sync_pulse` is high only at position 0 of frame 1, for one bit, whatever the value of `sync_wide`.
- R7: A multiframe is 12 frames in D4 mode and 24 frames in the other modes. After the last frame the count returns to frame 1.
- R8: The framing bit of a carrier frame is captured and driven on `link_data` from position 192 of that frame until the next update. Carrier frames are the even frames in D4, the odd frames in ESF, and frames 1, 5, 9, …, 21 in ZBTSI.
- R9: `link_clk` goes high at position 192 of a carrier frame and low at position 192 of the next frame. This gives a 4 kHz rate in D4 and ESF and a 2 kHz rate in ZBTSI.
- R10: The `mode` encoding is 0 = D4, 1 = ESF, 2 = ZBTSI. Code 3 behaves exactly like ESF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.544 MHz receive bit clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Framing mode: 0 D4, 1 ESF, 2 ZBTSI, 3 as ESF |
| sync_sel | input | 1 | 0 = pulse every frame, 1 = pulse every multiframe |
| sync_wide | input | 1 | Two-bit frame pulse on signaling frames |
| frame_align | input | 1 | Current bit is position 0 of frame 1 |
| rx_data | input | 1 | Receive serial data |
| chan_clk | output | 1 | High at the last bit of each channel |
| sync_pulse | output | 1 | Frame or multiframe sync pulse |
| link_clk | output | 1 | Overhead link clock |
| link_data | output | 1 | Overhead link data |

## Verification
Each output reaches its new value one register stage after the counters. It is valid in the same cycle as the bit it describes, so outputs show no extra delay relative to the bit stream. The alignment pulse only takes effect from the next cycle onward. The bench drives each bit on the falling edge and keeps a model of the position and frame number. In the same falling edge it compares the outputs against that model, and it skips only the alignment cycle itself. Link outputs are checked only after the first position-192 update that follows an alignment, because earlier values come from the previous alignment.

// File: rtl/t1rt_pkg.sv
package t1rt_pkg;

  typedef enum logic [1:0] {
    MODE_D4  = 2'd0,
    MODE_ESF = 2'd1,
    MODE_ZBT = 2'd2,
    MODE_ALT = 2'd3
  } t1_mode_e;

endpackage

// File: rtl/t1rt_counter.sv
module t1rt_counter
  import t1rt_pkg::*;
#(
  parameter int POS_W    = 8,
  parameter int FRM_W    = 5,
  parameter int LAST_POS = 192,
  parameter int D4_MF    = 12,
  parameter int EXT_MF   = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  t1_mode_e         mode,
  input  logic             frame_align,
  output logic [POS_W-1:0] cur_pos,
  output logic [POS_W-1:0] nxt_pos,
  output logic [FRM_W-1:0] nxt_frm
);

  logic [POS_W-1:0] pos_q;
  logic [FRM_W-1:0] frm_q;
  logic [FRM_W-1:0] cur_frm;
  logic [FRM_W-1:0] mf_len;

  always_comb begin
    cur_pos = frame_align ? '0 : pos_q;
    cur_frm = frame_align ? FRM_W'(1) : frm_q;
    mf_len  = (mode == MODE_D4) ? FRM_W'(D4_MF) : FRM_W'(EXT_MF);
    if (cur_pos == POS_W'(LAST_POS)) begin
      nxt_pos = '0;
      nxt_frm = (cur_frm >= mf_len) ? FRM_W'(1) : cur_frm + 1'b1;
    end else begin
      nxt_pos = cur_pos + 1'b1;
      nxt_frm = cur_frm;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      frm_q <= FRM_W'(1);
    end else begin
      pos_q <= nxt_pos;
      frm_q <= nxt_frm;
    end
  end

  a_r2_pos_range: assert property (@(posedge clk) disable iff (rst)
    pos_q <= POS_W'(LAST_POS));

  a_r2_pos_wrap: assert property (@(posedge clk) disable iff (rst)
    (pos_q == POS_W'(LAST_POS) && !frame_align) |=> (pos_q == '0));

  a_r7_frm_range: assert property (@(posedge clk) disable iff (rst)
    (frm_q >= FRM_W'(1)) && (frm_q <= FRM_W'(EXT_MF)));

endmodule

// File: rtl/t1rt_strobes.sv
module t1rt_strobes
  import t1rt_pkg::*;
#(
  parameter int POS_W   = 8,
  parameter int FRM_W   = 5,
  parameter int CH_BITS = 8,
  parameter int D4_MF   = 12,
  parameter int EXT_MF  = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  t1_mode_e         mode,
  input  logic             sync_sel,
  input  logic             sync_wide,
  input  logic [POS_W-1:0] nxt_pos,
  input  logic [FRM_W-1:0] nxt_frm,
  output logic             chan_clk,
  output logic             sync_pulse
);

  localparam logic [POS_W-1:0] CHB      = POS_W'(CH_BITS);
  localparam logic [FRM_W-1:0] SIG_STEP = FRM_W'(EXT_MF / 4);
  localparam logic [FRM_W-1:0] D4_HALF  = FRM_W'(D4_MF / 2);

  logic sig_frame;
  logic chan_d;
  logic sync_d;

  always_comb begin
    if (mode == MODE_D4)
      sig_frame = (nxt_frm == D4_HALF) || (nxt_frm == FRM_W'(D4_MF));
    else
      sig_frame = (nxt_frm % SIG_STEP) == '0;

    chan_d = (nxt_pos != '0) && ((nxt_pos % CHB) == '0);

    if (sync_sel)
      sync_d = (nxt_pos == '0) && (nxt_frm == FRM_W'(1));
    else
      sync_d = (nxt_pos == '0) ||
               (sync_wide && sig_frame && (nxt_pos == POS_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_clk   <= 1'b0;
      sync_pulse <= 1'b0;
    end else begin
      chan_clk   <= chan_d;
      sync_pulse <= sync_d;
    end
  end

  a_r3_chan_gap: assert property (@(posedge clk) disable iff (rst)
    chan_clk |=> !chan_clk);

  a_r5_sync_max_two: assert property (@(posedge clk) disable iff (rst)
    (sync_pulse && $past(sync_pulse)) |=> !sync_pulse);

endmodule

// File: rtl/t1rt_link.sv
module t1rt_link
  import t1rt_pkg::*;
#(
  parameter int POS_W    = 8,
  parameter int FRM_W    = 5,
  parameter int LAST_POS = 192
) (
  input  logic             clk,
  input  logic             rst,
  input  t1_mode_e         mode,
  input  logic             rx_data,
  input  logic [POS_W-1:0] cur_pos,
  input  logic [POS_W-1:0] nxt_pos,
  input  logic [FRM_W-1:0] nxt_frm,
  output logic             link_clk,
  output logic             link_data
);

  logic fbit_q;
  logic carrier;

  always_comb begin
    unique case (mode)
      MODE_D4:  carrier = !nxt_frm[0];
      MODE_ZBT: carrier = (nxt_frm[1:0] == 2'b01);
      default:  carrier = nxt_frm[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fbit_q    <= 1'b0;
      link_clk  <= 1'b0;
      link_data <= 1'b0;
    end else begin
      if (cur_pos == '0)
        fbit_q <= rx_data;
      if (nxt_pos == POS_W'(LAST_POS)) begin
        link_clk <= carrier;
        if (carrier)
          link_data <= fbit_q;
      end
    end
  end

  a_r8_data_with_clk: assert property (@(posedge clk) disable iff (rst)
    !$stable(link_data) |-> link_clk);

  a_r9_clk_rise_at_last: assert property (@(posedge clk) disable iff (rst)
    $rose(link_clk) |-> $past(nxt_pos == POS_W'(LAST_POS)));

endmodule

// File: rtl/t1_rx_timing.sv
module t1_rx_timing
  import t1rt_pkg::*;
#(
  parameter int CHANNELS = 24,
  parameter int CH_BITS  = 8,
  parameter int D4_MF    = 12,
  parameter int EXT_MF   = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       sync_sel,
  input  logic       sync_wide,
  input  logic       frame_align,
  input  logic       rx_data,
  output logic       chan_clk,
  output logic       sync_pulse,
  output logic       link_clk,
  output logic       link_data
);

  localparam int LAST_POS = CHANNELS * CH_BITS;
  localparam int POS_W    = $clog2(LAST_POS + 1);
  localparam int FRM_W    = $clog2(EXT_MF + 1);

  t1_mode_e         mode_e;
  logic [POS_W-1:0] cur_pos;
  logic [POS_W-1:0] nxt_pos;
  logic [FRM_W-1:0] nxt_frm;

  assign mode_e = t1_mode_e'(mode);

  t1rt_counter #(
    .POS_W(POS_W), .FRM_W(FRM_W), .LAST_POS(LAST_POS),
    .D4_MF(D4_MF), .EXT_MF(EXT_MF)
  ) u_counter (
    .clk(clk), .rst(rst), .mode(mode_e), .frame_align(frame_align),
    .cur_pos(cur_pos), .nxt_pos(nxt_pos), .nxt_frm(nxt_frm)
  );

  t1rt_strobes #(
    .POS_W(POS_W), .FRM_W(FRM_W), .CH_BITS(CH_BITS),
    .D4_MF(D4_MF), .EXT_MF(EXT_MF)
  ) u_strobes (
    .clk(clk), .rst(rst), .mode(mode_e), .sync_sel(sync_sel),
    .sync_wide(sync_wide), .nxt_pos(nxt_pos), .nxt_frm(nxt_frm),
    .chan_clk(chan_clk), .sync_pulse(sync_pulse)
  );

  t1rt_link #(
    .POS_W(POS_W), .FRM_W(FRM_W), .LAST_POS(LAST_POS)
  ) u_link (
    .clk(clk), .rst(rst), .mode(mode_e), .rx_data(rx_data),
    .cur_pos(cur_pos), .nxt_pos(nxt_pos), .nxt_frm(nxt_frm),
    .link_clk(link_clk), .link_data(link_data)
  );

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    $past(rst) |-> !(chan_clk || sync_pulse || link_clk || link_data));

endmodule

// File: tb/test_t1_rx_timing.sv
module test_t1_rx_timing;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic       sync_sel = 1'b0;
  logic       sync_wide = 1'b0;
  logic       frame_align = 1'b0;
  logic       rx_data = 1'b0;
  logic       chan_clk, sync_pulse, link_clk, link_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  t1_rx_timing i_t1_rx_timing (
    .clk(clk), .rst(rst), .mode(mode), .sync_sel(sync_sel),
    .sync_wide(sync_wide), .frame_align(frame_align), .rx_data(rx_data),
    .chan_clk(chan_clk), .sync_pulse(sync_pulse),
    .link_clk(link_clk), .link_data(link_data)
  );

  function automatic int mf_len(int m);
    return (m == 0) ? 12 : 24;
  endfunction

  function automatic bit is_sig(int m, int f);
    if (m == 0) return (f == 6) || (f == 12);
    return (f % 6) == 0;
  endfunction

  function automatic bit is_carrier(int m, int f);
    if (m == 0) return (f % 2) == 0;
    if (m == 2) return (f % 4) == 1;
    return (f % 2) == 1;
  endfunction

  function automatic bit exp_sync(int m, bit sel, bit wide, int p, int f);
    if (sel) return (p == 0) && (f == 1);
    return (p == 0) || (wide && p == 1 && is_sig(m, f));
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Runs one segment: align on the first bit and again at realign_at.
  task automatic run_seg(int m, bit sel, bit wide, int nbits, int realign_at);
    int  mp = 0, mf = 1, since = 0;
    bit  lc_known = 0, ld_known = 0, exp_lc = 0, exp_ld = 0, sh = 0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      if (i == 0 || i == realign_at) begin
        mode = 2'(m); sync_sel = sel; sync_wide = wide;
        frame_align = 1'b1;
        mp = 0; mf = 1; since = 0;
        lc_known = 0; ld_known = 0;
      end else begin
        string stag;
        frame_align = 1'b0;
        if (mp == 192) begin
          if (is_carrier(m, mf)) begin
            exp_ld = sh; exp_lc = 1; ld_known = 1;
          end else exp_lc = 0;
          lc_known = 1;
        end
        check((m == 3) ? "R10 R3 chan" : "R3 chan", chan_clk,
              (mp != 0) && (mp % 8 == 0));
        if (since <= 193)     stag = "R2 sync after align";
        else if (sel)         stag = "R6 R7 multiframe sync";
        else if (wide)        stag = "R5 wide sync";
        else                  stag = "R4 frame sync";
        check(stag, sync_pulse, exp_sync(m, sel, wide, mp, mf));
        if (lc_known) check("R9 link_clk", link_clk, exp_lc);
        if (ld_known) check("R8 link_data", link_data, exp_ld);
      end
      rx_data = 1'($urandom);
      if (mp == 0) sh = rx_data;
      since++;
      if (mp == 192) begin
        mp = 0;
        mf = (mf >= mf_len(m)) ? 1 : mf + 1;
      end else mp++;
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 195000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected < 195000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd2152));
    repeat (4) @(negedge clk);
    check("R1 reset chan", chan_clk, 1'b0);
    check("R1 reset sync", sync_pulse, 1'b0);
    check("R1 reset lclk", link_clk, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 post-reset chan", chan_clk, 1'b0);
    check("R1 post-reset sync", sync_pulse, 1'b0);
    check("R1 post-reset link", link_clk | link_data, 1'b0);

    // Directed configurations, realignment at a random mid-frame point.
    run_seg(0, 0, 0, 5400, 2600 + int'($urandom_range(0, 190)));
    run_seg(0, 0, 1, 5400, -1);
    run_seg(0, 1, 1, 5400, -1);
    run_seg(1, 0, 1, 9500, 4700 + int'($urandom_range(0, 190)));
    run_seg(1, 1, 0, 9500, -1);
    run_seg(2, 0, 0, 9500, -1);
    run_seg(2, 0, 1, 9500, 3000 + int'($urandom_range(0, 190)));
    run_seg(3, 0, 1, 9500, -1);
    // Random configurations.
    for (int k = 0; k < 4; k++)
      run_seg(int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
              9500, int'($urandom_range(1000, 8000)));
    finish_run();
  end

endmodule